// File: doc/BRIEF.md
# Cache Line Mark-Bit Tracker

This block keeps the bookkeeping that lets software transactions track their read sets cheaply. It models only the tag, valid and mark metadata of a small direct-mapped cache. Software sends a check-and-mark request with an address. One cycle later the block answers whether that cache block was already marked and has stayed untouched since it was marked. The same access leaves the block marked. A probe variant of the request reports the same answer without changing any state.

Two more inputs carry line removals. The snoop input takes addresses written or invalidated by other agents. The eviction input takes addresses of lines the cache has displaced. Either kind of removal drops the line's mark, and a local allocation that overwrites a marked line does the same. Whenever a marked line is lost this way, a sticky loss flag rises. Software can read the flag at any moment to learn whether it must fall back to full validation. A clear command wipes every mark and the loss flag in one cycle.

Top module: `line_mark_tracker`

## Requirements
- R1: After reset, respValid and lossFlag are 0, and every line is invalid, so the first check of any address reports respMarked = 0.
- R2: A check-and-mark (chkMode = 1) that misses allocates the line with its mark set and reports 0. A later check of the same block reports 1.
- R3: respValid is 1 exactly in the cycle after a cycle with chkValid = 1, and 0 after a cycle with chkValid = 0.
- R4: A probe (chkMode = 0) reports whether the block is resident and marked, and changes no state. A probe that misses does not allocate.
- R5: Marking works on 64-byte blocks. Addresses that differ only in bits [5:0] share one mark. Bits [11:6] select one of 64 lines, and bits [31:12] form the tag.
- R6: A snoop address that hits a marked resident line invalidates the line and sets lossFlag. Later checks of that block report 0.
- R7: An eviction address that hits a marked resident line invalidates the line and sets lossFlag.
- R8: A check-and-mark that allocates over a valid marked line of another block sets lossFlag. The displaced block then reports 0.
- R9: A snoop or an eviction that misses, or that hits a valid unmarked line, leaves lossFlag at 0.
- R10: lossFlag stays 1 until a clear command arrives, whatever other traffic occurs.
- R11: clearMarks drops every mark and lossFlag in one cycle. A local request in the same cycle reports 0 and has no effect on state.
- R12: When a snoop or an eviction names the same block as a local request in the same cycle, the removal wins. The local request reports 0 and leaves the block unmarked and non-resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| chkValid | input | 1 | Local request strobe |
| chkMode | input | 1 | 1 = check-and-mark, 0 = probe only |
| chkAddr | input | ADDR_W | Local request byte address |
| snoopValid | input | 1 | Remote write or invalidation strobe |
| snoopAddr | input | ADDR_W | Remote write or invalidation address |
| evictValid | input | 1 | Line displacement strobe |
| evictAddr | input | ADDR_W | Address of the displaced line |
| clearMarks | input | 1 | Drop all marks and the loss flag |
| respValid | output | 1 | Response strobe, one cycle after a request |
| respMarked | output | 1 | Block was marked and untouched before this request |
| lossFlag | output | 1 | Sticky: some marked line has been lost |

## Verification
The assertions assume that every input is at a known level on each rising edge. They also assume that an address is only meaningful while its strobe is high, which holds because the block compares addresses only under their strobes. The same-cycle conflict property assumes that removal addresses are compared with the local address at block granularity. The bench keeps within these limits by driving every input on the falling edge and by returning strobes and addresses to zero between requests. Each scenario therefore leaves a clean, known state for the next.

// File: rtl/mark_track_pkg.sv
package mark_track_pkg;

  // Strobes from the control to the metadata store, one cycle's worth.
  typedef struct packed {
    logic clearAll;  // drop every mark
    logic snInval;   // invalidate the line at the snoop index
    logic evInval;   // invalidate the line at the eviction index
    logic alloc;     // install local tag with mark set
    logic setMark;   // set mark on the resident local line
  } strobe_t;

endpackage

// File: rtl/mark_track_store.sv
module mark_track_store
  import mark_track_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = 6,
  parameter int TAG_W     = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [IDX_W-1:0] chkIdx,
  input  logic [TAG_W-1:0] chkTag,
  input  logic [IDX_W-1:0] snIdx,
  input  logic [IDX_W-1:0] evIdx,
  output logic             chkLineValid,
  output logic             chkLineMark,
  output logic [TAG_W-1:0] chkLineTag,
  output logic             snLineValid,
  output logic             snLineMark,
  output logic [TAG_W-1:0] snLineTag,
  output logic             evLineValid,
  output logic             evLineMark,
  output logic [TAG_W-1:0] evLineTag
);

  logic [NUM_LINES-1:0] validVec;
  logic [NUM_LINES-1:0] markVec;
  logic [TAG_W-1:0]     tagArr [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic             lineValid;
    logic             lineMark;
    logic [TAG_W-1:0] lineTag;
    logic             hitSn;
    logic             hitEv;
    logic             hitLocal;

    assign hitSn    = stb.snInval && (snIdx == IDX_W'(i));
    assign hitEv    = stb.evInval && (evIdx == IDX_W'(i));
    assign hitLocal = (chkIdx == IDX_W'(i));

    // Later statements take priority: removals first, then the local write.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid <= 1'b0;
        lineMark  <= 1'b0;
      end else begin
        if (stb.clearAll) lineMark <= 1'b0;
        if (hitSn || hitEv) begin
          lineValid <= 1'b0;
          lineMark  <= 1'b0;
        end
        if (stb.alloc && hitLocal) begin
          lineValid <= 1'b1;
          lineMark  <= 1'b1;
        end
        if (stb.setMark && hitLocal) lineMark <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (stb.alloc && hitLocal) lineTag <= chkTag;
    end

    assign validVec[i] = lineValid;
    assign markVec[i]  = lineMark;
    assign tagArr[i]   = lineTag;
  end

  assign chkLineValid = validVec[chkIdx];
  assign chkLineMark  = markVec[chkIdx];
  assign chkLineTag   = tagArr[chkIdx];
  assign snLineValid  = validVec[snIdx];
  assign snLineMark   = markVec[snIdx];
  assign snLineTag    = tagArr[snIdx];
  assign evLineValid  = validVec[evIdx];
  assign evLineMark   = markVec[evIdx];
  assign evLineTag    = tagArr[evIdx];

  // R2: a mark only ever lives on a resident line
  p_mark_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((markVec & ~validVec) == '0));

  // R11: after a clear cycle no line holds a mark
  p_clear_drops_marks_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (markVec == '0));

endmodule

// File: rtl/mark_track_ctrl.sv
module mark_track_ctrl
  import mark_track_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkValid,
  input  logic              chkMode,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic              clearMarks,
  input  logic              chkLineValid,
  input  logic              chkLineMark,
  input  logic [TAG_W-1:0]  chkLineTag,
  input  logic              snLineValid,
  input  logic              snLineMark,
  input  logic [TAG_W-1:0]  snLineTag,
  input  logic              evLineValid,
  input  logic              evLineMark,
  input  logic [TAG_W-1:0]  evLineTag,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  chkIdx,
  output logic [TAG_W-1:0]  chkTag,
  output logic [IDX_W-1:0]  snIdx,
  output logic [IDX_W-1:0]  evIdx,
  output logic              respValid,
  output logic              respMarked,
  output logic              lossFlag
);

  logic [TAG_W-1:0] snTag, evTag;
  logic chkHit, snHit, evHit;
  logic snClash, evClash, localGo, lossEvent;

  assign chkIdx = chkAddr[OFF_W +: IDX_W];
  assign chkTag = chkAddr[ADDR_W-1 -: TAG_W];
  assign snIdx  = snoopAddr[OFF_W +: IDX_W];
  assign snTag  = snoopAddr[ADDR_W-1 -: TAG_W];
  assign evIdx  = evictAddr[OFF_W +: IDX_W];
  assign evTag  = evictAddr[ADDR_W-1 -: TAG_W];

  assign chkHit = chkLineValid && (chkLineTag == chkTag);
  assign snHit  = snLineValid && (snLineTag == snTag);
  assign evHit  = evLineValid && (evLineTag == evTag);

  // Same-block comparison ignores the byte offset within the line.
  assign snClash = snoopValid && (((snoopAddr ^ chkAddr) >> OFF_W) == '0);
  assign evClash = evictValid && (((evictAddr ^ chkAddr) >> OFF_W) == '0);
  assign localGo = chkValid && !clearMarks && !snClash && !evClash;

  always_comb begin
    stb          = '0;
    stb.clearAll = clearMarks;
    stb.snInval  = snoopValid && snHit;
    stb.evInval  = evictValid && evHit;
    stb.alloc    = localGo && chkMode && !chkHit;
    stb.setMark  = localGo && chkMode && chkHit;
  end

  assign lossEvent = (stb.snInval && snLineMark)
                  || (stb.evInval && evLineMark)
                  || (stb.alloc && chkLineValid && chkLineMark);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respMarked <= 1'b0;
      lossFlag   <= 1'b0;
    end else begin
      respValid  <= chkValid;
      respMarked <= localGo && chkHit && chkLineMark;
      lossFlag   <= clearMarks ? 1'b0 : (lossFlag || lossEvent);
    end
  end

  // R3: response strobe follows the request by one cycle
  p_resp_timing_r3: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> respValid);
  p_resp_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !respValid);

  // R2: a positive answer only comes with a response strobe
  p_marked_needs_resp_r2: assert property (@(posedge clk) disable iff (!rstN)
    respMarked |-> respValid);

  // R10: loss flag holds until cleared
  p_loss_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lossFlag && !clearMarks) |=> lossFlag);

  // R11: clear drops the loss flag
  p_clear_loss_r11: assert property (@(posedge clk) disable iff (!rstN)
    clearMarks |=> !lossFlag);

  // R12: a same-block removal forces a "not unchanged" answer
  p_clash_unchanged_r12: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && snoopValid && (((snoopAddr ^ chkAddr) >> OFF_W) == '0)) |=> !respMarked);

endmodule

// File: rtl/line_mark_tracker.sv
module line_mark_tracker
  import mark_track_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_LINES  = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkValid,
  input  logic              chkMode,
  input  logic [ADDR_W-1:0] chkAddr,
  input  logic              snoopValid,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic              clearMarks,
  output logic              respValid,
  output logic              respMarked,
  output logic              lossFlag
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  strobe_t          stb;
  logic [IDX_W-1:0] chkIdx, snIdx, evIdx;
  logic [TAG_W-1:0] chkTag;
  logic             chkLineValid, chkLineMark;
  logic             snLineValid, snLineMark;
  logic             evLineValid, evLineMark;
  logic [TAG_W-1:0] chkLineTag, snLineTag, evLineTag;

  mark_track_ctrl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .chkValid(chkValid), .chkMode(chkMode), .chkAddr(chkAddr),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .evictValid(evictValid), .evictAddr(evictAddr),
    .clearMarks(clearMarks),
    .chkLineValid(chkLineValid), .chkLineMark(chkLineMark), .chkLineTag(chkLineTag),
    .snLineValid(snLineValid), .snLineMark(snLineMark), .snLineTag(snLineTag),
    .evLineValid(evLineValid), .evLineMark(evLineMark), .evLineTag(evLineTag),
    .stb(stb), .chkIdx(chkIdx), .chkTag(chkTag), .snIdx(snIdx), .evIdx(evIdx),
    .respValid(respValid), .respMarked(respMarked), .lossFlag(lossFlag)
  );

  mark_track_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .chkIdx(chkIdx), .chkTag(chkTag), .snIdx(snIdx), .evIdx(evIdx),
    .chkLineValid(chkLineValid), .chkLineMark(chkLineMark), .chkLineTag(chkLineTag),
    .snLineValid(snLineValid), .snLineMark(snLineMark), .snLineTag(snLineTag),
    .evLineValid(evLineValid), .evLineMark(evLineMark), .evLineTag(evLineTag)
  );

endmodule

// File: tb/sim_line_mark_tracker.sv
`timescale 1ns/1ps
module sim_line_mark_tracker;

  logic        clk = 1'b0;
  logic        rstN;
  logic        chkValid, chkMode, snoopValid, evictValid, clearMarks;
  logic [31:0] chkAddr, snoopAddr, evictAddr;
  logic        respValid, respMarked, lossFlag;
  int          nTests = 0;
  int          nFail  = 0;
  logic        done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  line_mark_tracker u0 (
    .clk(clk), .rstN(rstN),
    .chkValid(chkValid), .chkMode(chkMode), .chkAddr(chkAddr),
    .snoopValid(snoopValid), .snoopAddr(snoopAddr),
    .evictValid(evictValid), .evictAddr(evictAddr),
    .clearMarks(clearMarks),
    .respValid(respValid), .respMarked(respMarked), .lossFlag(lossFlag)
  );

  function automatic logic [31:0] mk(input int tag, input int idx, input int off);
    return (32'(tag) << 12) | (32'(idx) << 6) | 32'(off);
  endfunction

  task automatic expect1(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    chkValid = 0; chkMode = 0; chkAddr = '0;
    snoopValid = 0; snoopAddr = '0;
    evictValid = 0; evictAddr = '0;
    clearMarks = 0;
  endtask

  // Drive one cycle of stimulus, then sample at the following falling edge.
  task automatic step(input logic cv, input logic cm, input logic [31:0] ca,
                      input logic sv, input logic [31:0] sa,
                      input logic ev, input logic [31:0] ea, input logic clr);
    @(negedge clk);
    chkValid = cv; chkMode = cm; chkAddr = ca;
    snoopValid = sv; snoopAddr = sa;
    evictValid = ev; evictAddr = ea;
    clearMarks = clr;
    @(negedge clk);
    idleInputs();
  endtask

  task automatic chk(input logic [31:0] a, input logic mode);
    step(1, mode, a, 0, '0, 0, '0, 0);
  endtask

  task automatic clearAll();
    step(0, 0, '0, 0, '0, 0, '0, 1);
  endtask

  task automatic tReset();
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    expect1("R1 respValid in reset", respValid, 0);
    expect1("R1 lossFlag in reset", lossFlag, 0);
    rstN = 1;
    chk(mk(1, 3, 0), 1);
    expect1("R1 first check unmarked", respMarked, 0);
    expect1("R3 respValid after request", respValid, 1);
  endtask

  task automatic tMark();
    chk(mk(1, 3, 0), 1);
    expect1("R2 second check marked", respMarked, 1);
    chk(mk(1, 3, 60), 1);
    expect1("R5 same block other offset", respMarked, 1);
    chk(mk(2, 4, 0), 1);
    expect1("R2 new block unmarked", respMarked, 0);
    chk(mk(2, 4, 0), 1);
    expect1("R2 new block now marked", respMarked, 1);
    expect1("R9 no loss from fresh allocs", lossFlag, 0);
  endtask

  task automatic tTiming();
    chk(mk(2, 4, 0), 1);
    expect1("R3 respValid in response cycle", respValid, 1);
    @(negedge clk);
    expect1("R3 respValid drops when idle", respValid, 0);
    expect1("R3 respMarked drops when idle", respMarked, 0);
  endtask

  task automatic tProbe();
    chk(mk(3, 7, 0), 0);
    expect1("R4 probe of absent block", respMarked, 0);
    chk(mk(3, 7, 0), 0);
    expect1("R4 probe does not allocate", respMarked, 0);
    chk(mk(1, 3, 0), 0);
    expect1("R4 probe of marked block", respMarked, 1);
    chk(mk(1, 3, 0), 1);
    expect1("R4 probe left mark intact", respMarked, 1);
  endtask

  task automatic tSnoop();
    step(0, 0, '0, 1, mk(1, 3, 16), 0, '0, 0);
    expect1("R6 snoop on marked line sets loss", lossFlag, 1);
    chk(mk(1, 3, 0), 0);
    expect1("R6 snooped block reports unmarked", respMarked, 0);
    chk(mk(2, 4, 0), 0);
    expect1("R6 other line untouched", respMarked, 1);
  endtask

  task automatic tClear();
    clearAll();
    expect1("R11 clear drops loss", lossFlag, 0);
    chk(mk(2, 4, 0), 0);
    expect1("R11 clear drops mark", respMarked, 0);
    step(1, 1, mk(4, 8, 0), 0, '0, 0, '0, 1);
    expect1("R11 request during clear reports 0", respMarked, 0);
    chk(mk(4, 8, 0), 0);
    expect1("R11 request during clear not applied", respMarked, 0);
  endtask

  task automatic tNoLoss();
    step(0, 0, '0, 1, mk(2, 4, 0), 0, '0, 0);
    expect1("R9 snoop on unmarked line", lossFlag, 0);
    step(0, 0, '0, 0, '0, 1, mk(5, 9, 0), 0);
    expect1("R9 evict of absent line", lossFlag, 0);
    step(0, 0, '0, 1, mk(77, 20, 0), 0, '0, 0);
    expect1("R9 snoop of absent line", lossFlag, 0);
  endtask

  task automatic tEvict();
    chk(mk(6, 10, 0), 1);
    expect1("R7 setup alloc", respMarked, 0);
    step(0, 0, '0, 0, '0, 1, mk(6, 10, 32), 0);
    expect1("R7 evict of marked line sets loss", lossFlag, 1);
    chk(mk(6, 10, 0), 0);
    expect1("R7 evicted block unmarked", respMarked, 0);
    repeat (3) @(negedge clk);
    expect1("R10 loss holds over idle", lossFlag, 1);
    chk(mk(1, 3, 0), 1);
    expect1("R10 loss holds over traffic", lossFlag, 1);
    clearAll();
    expect1("R10 loss released by clear", lossFlag, 0);
  endtask

  task automatic tReplace();
    chk(mk(7, 5, 0), 1);
    expect1("R8 setup alloc", lossFlag, 0);
    chk(mk(8, 5, 0), 1);
    expect1("R8 replacing marked line sets loss", lossFlag, 1);
    chk(mk(7, 5, 0), 0);
    expect1("R8 displaced block unmarked", respMarked, 0);
    chk(mk(8, 5, 0), 0);
    expect1("R8 new block marked", respMarked, 1);
    clearAll();
  endtask

  task automatic tConflict();
    chk(mk(9, 11, 0), 1);
    step(1, 1, mk(9, 11, 0), 1, mk(9, 11, 4), 0, '0, 0);
    expect1("R12 snoop clash reports 0", respMarked, 0);
    expect1("R12 snoop clash on marked line sets loss", lossFlag, 1);
    chk(mk(9, 11, 0), 0);
    expect1("R12 clashed block not resident", respMarked, 0);
    clearAll();
    step(1, 1, mk(10, 12, 0), 1, mk(10, 12, 0), 0, '0, 0);
    expect1("R12 clash on absent block reports 0", respMarked, 0);
    expect1("R12 clash on absent block no loss", lossFlag, 0);
    chk(mk(10, 12, 0), 0);
    expect1("R12 clash did not allocate", respMarked, 0);
    chk(mk(9, 11, 0), 1);
    step(1, 1, mk(9, 11, 0), 0, '0, 1, mk(9, 11, 8), 0);
    expect1("R12 evict clash reports 0", respMarked, 0);
    expect1("R12 evict clash sets loss", lossFlag, 1);
    clearAll();
  endtask

  initial begin
    tReset();
    tMark();
    tTiming();
    tProbe();
    tSnoop();
    tClear();
    tNoLoss();
    tEvict();
    tReplace();
    tConflict();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule